// File: doc/BRIEF.md
# Compact Branch and Link Unit

This unit executes the branch-class instructions of a 16-bit compact instruction set. On each cycle where `issue` is high it takes the current halfword instruction, the halfword that follows it, the halfword-aligned address of the current instruction and the four condition flags (negative, zero, carry, overflow). On the next clock edge it reports whether the program counter is redirected, the redirect target, and whether the instruction was a software interrupt or an undefined encoding. It also updates the link register copy that it owns.

The unit handles four kinds of branch. The first is the conditional short branch, which checks a 4-bit condition against the flags. The second is the unconditional branch. The third and fourth are the two halves of a long branch-with-link, which splits a 22-bit offset across two halfwords. When the upper half is issued and the next halfword is the lower half, the two are fused and run as one operation. The fetch logic uses `pair_fused` to learn that it must skip the second halfword.

A lone lower half is also accepted. It uses whatever the link register holds at that moment. Software interrupts and undefined encodings are only flagged; their dispatch belongs to other logic. All address arithmetic is 32-bit and wraps around.

Top module: `cbl_unit`

## Requirements
- R1: After reset, `redirect`, `swi_hit`, `undef_hit` and `pair_fused` are 0 and `link` is 0.
- R2: The instruction class is taken from `instr[15:11]`. Opcode 26 or 27 (binary 1101x) is a conditional branch whose condition is `instr[11:8]`. Condition 15 raises `swi_hit`, condition 14 raises `undef_hit`, and neither redirects.
- R3: Conditions 0 to 13 hold as follows: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R4: A conditional branch whose condition holds redirects to pc+4 plus `instr[7:0]` sign-extended from bit 7 and shifted left by 1. A condition that fails gives no redirect and no link change.
- R5: Opcode 28 redirects to pc+4 plus `instr[10:0]` sign-extended from bit 10 and shifted left by 1.
- R6: Opcode 29 raises `undef_hit` and does not redirect.
- R7: Opcode 30 without a following opcode 31 sets `link` to pc+4 plus `instr[10:0]` sign-extended from bit 10 and shifted left by 12. It does not redirect.
- R8: Opcode 30 followed by `next_instr[15:11]`=31 raises `pair_fused`. It redirects to the R7 link value plus `next_instr[10:0]` shifted left by 1, and it sets `link` to (pc+4) with bit 0 set.
- R9: A lone opcode 31 redirects to the current `link` plus `instr[10:0]` shifted left by 1. It sets `link` to (pc+2) with bit 0 set.
- R10: `redirect`, `swi_hit`, `undef_hit` and `pair_fused` are one-cycle pulses that appear the cycle after an issue. Without `issue`, or for any non-branch opcode (0 to 25), they stay 0 and `link` is unchanged.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Current halfword instruction |
| next_instr | input | 16 | Following halfword |
| pc | input | 32 | Address of the current instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| redirect | output | 1 | PC redirect and pipeline flush pulse |
| new_pc | output | 32 | Redirect target, valid with `redirect` |
| link | output | 32 | Link register copy |
| pair_fused | output | 1 | Long branch pair executed as one |
| swi_hit | output | 1 | Software interrupt seen |
| undef_hit | output | 1 | Undefined encoding seen |

## Verification
The hardest case to reach is a lone lower half of the long branch, because its target depends on link state left behind by earlier instructions. The stimulus first leaves a known value in `link` with an upper half that has no partner, or with a fused pair whose link carries bit 0 set. It then issues a lone lower half and checks the resulting link chain. The conditional branch is swept over all sixteen condition codes against all sixteen flag combinations. Offsets and PCs vary, including PCs near the top of the address space, so wraparound is exercised.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int ADDR_W  = 32;
  localparam int HW_W    = 16;
  localparam int OPC_W   = 5;
  localparam int OFF_S_W = 8;
  localparam int OFF_L_W = 11;

  localparam logic [OPC_W-1:0] OPC_BCC_LO = 5'd26;
  localparam logic [OPC_W-1:0] OPC_BCC_HI = 5'd27;
  localparam logic [OPC_W-1:0] OPC_B      = 5'd28;
  localparam logic [OPC_W-1:0] OPC_HOLE   = 5'd29;
  localparam logic [OPC_W-1:0] OPC_BL_HI  = 5'd30;
  localparam logic [OPC_W-1:0] OPC_BL_LO  = 5'd31;

  localparam logic [3:0] CC_UNDEF = 4'd14;
  localparam logic [3:0] CC_SWI   = 4'd15;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic bcc;
    logic b;
    logic bl_hi;
    logic bl_lo;
    logic fused;
    logic swi;
    logic undef;
  } cls_t;

  function automatic addr_t short_off(input logic [OFF_S_W-1:0] o);
    return {{(ADDR_W-OFF_S_W-1){o[OFF_S_W-1]}}, o, 1'b0};
  endfunction

  function automatic addr_t long_off(input logic [OFF_L_W-1:0] o);
    return {{(ADDR_W-OFF_L_W-1){o[OFF_L_W-1]}}, o, 1'b0};
  endfunction

  function automatic addr_t link_hi_off(input logic [OFF_L_W-1:0] o);
    return {{(ADDR_W-OFF_L_W-12){o[OFF_L_W-1]}}, o, 12'b0};
  endfunction

  function automatic addr_t link_lo_off(input logic [OFF_L_W-1:0] o);
    return {{(ADDR_W-OFF_L_W-1){1'b0}}, o, 1'b0};
  endfunction
endpackage

// File: rtl/cbl_cond_eval.sv
module cbl_cond_eval (
  input  logic [3:0] cc,
  input  logic       n,
  input  logic       z,
  input  logic       c,
  input  logic       v,
  output logic       holds
);
  logic base;
  logic nv_eq;
  assign nv_eq = (n == v);

  always_comb begin
    unique case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = nv_eq;
      3'd6: base = ~z & nv_eq;
      default: base = 1'b1;
    endcase
    holds = (cc[3:1] == 3'd7) ? 1'b0 : (base ^ cc[0]);
  end

  always_comb begin
    if (cc == 4'd12) a_r3_gt_needs_not_z: assert (!(holds && z));
    if (cc == 4'd13) a_r3_le_on_z: assert (!z || holds);
  end
endmodule

// File: rtl/cbl_classify.sv
module cbl_classify
  import cbl_pkg::*;
(
  input  logic [HW_W-1:0] instr,
  input  logic [HW_W-1:0] next_instr,
  output cls_t            cls
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] nopc;
  logic [3:0]       cc;
  logic             is_cond_grp;

  assign opc  = instr[HW_W-1 -: OPC_W];
  assign nopc = next_instr[HW_W-1 -: OPC_W];
  assign cc   = instr[11:8];
  assign is_cond_grp = (opc == OPC_BCC_LO) || (opc == OPC_BCC_HI);

  always_comb begin
    cls       = '0;
    cls.bcc   = is_cond_grp && (cc != CC_SWI) && (cc != CC_UNDEF);
    cls.swi   = is_cond_grp && (cc == CC_SWI);
    cls.undef = (is_cond_grp && (cc == CC_UNDEF)) || (opc == OPC_HOLE);
    cls.b     = (opc == OPC_B);
    cls.bl_hi = (opc == OPC_BL_HI);
    cls.bl_lo = (opc == OPC_BL_LO);
    cls.fused = cls.bl_hi && (nopc == OPC_BL_LO);
  end

  always_comb begin
    a_r2_classes_exclusive: assert ($countones({cls.bcc, cls.swi, cls.undef, cls.b, cls.bl_hi, cls.bl_lo}) <= 1);
  end
endmodule

// File: rtl/cbl_target.sv
module cbl_target
  import cbl_pkg::*;
(
  input  logic [HW_W-1:0] instr,
  input  logic [HW_W-1:0] next_instr,
  input  addr_t           pc,
  input  addr_t           link_cur,
  output addr_t           tgt_short,
  output addr_t           tgt_long,
  output addr_t           link_hi,
  output addr_t           tgt_pair,
  output addr_t           link_pair,
  output addr_t           tgt_lone,
  output addr_t           link_lone
);
  addr_t pc_plus2;
  addr_t pc_plus4;

  assign pc_plus2  = pc + addr_t'(2);
  assign pc_plus4  = pc + addr_t'(4);
  assign tgt_short = pc_plus4 + short_off(instr[OFF_S_W-1:0]);
  assign tgt_long  = pc_plus4 + long_off(instr[OFF_L_W-1:0]);
  assign link_hi   = pc_plus4 + link_hi_off(instr[OFF_L_W-1:0]);
  assign tgt_pair  = link_hi + link_lo_off(next_instr[OFF_L_W-1:0]);
  assign link_pair = pc_plus4 | addr_t'(1);
  assign tgt_lone  = link_cur + link_lo_off(instr[OFF_L_W-1:0]);
  assign link_lone = pc_plus2 | addr_t'(1);
endmodule

// File: rtl/cbl_unit.sv
module cbl_unit
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [HW_W-1:0]   instr,
  input  logic [HW_W-1:0]   next_instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              redirect,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] link,
  output logic              pair_fused,
  output logic              swi_hit,
  output logic              undef_hit
);
  cls_t  cls;
  logic  cond_ok;
  addr_t tgt_short, tgt_long, link_hi, tgt_pair, link_pair, tgt_lone, link_lone;
  addr_t link_q;

  // named internal events
  logic  take_bcc;
  logic  redirect_d;
  logic  link_we;
  addr_t target_d;
  addr_t link_d;

  cbl_classify u_cls (
    .instr      (instr),
    .next_instr (next_instr),
    .cls        (cls)
  );

  cbl_cond_eval u_cond (
    .cc    (instr[11:8]),
    .n     (flag_n),
    .z     (flag_z),
    .c     (flag_c),
    .v     (flag_v),
    .holds (cond_ok)
  );

  cbl_target u_tgt (
    .instr      (instr),
    .next_instr (next_instr),
    .pc         (pc),
    .link_cur   (link_q),
    .tgt_short  (tgt_short),
    .tgt_long   (tgt_long),
    .link_hi    (link_hi),
    .tgt_pair   (tgt_pair),
    .link_pair  (link_pair),
    .tgt_lone   (tgt_lone),
    .link_lone  (link_lone)
  );

  assign take_bcc   = cls.bcc & cond_ok;
  assign redirect_d = take_bcc | cls.b | cls.fused | cls.bl_lo;
  assign link_we    = cls.bl_hi | cls.bl_lo;

  always_comb begin
    target_d = tgt_short;
    if (cls.b)     target_d = tgt_long;
    if (cls.fused) target_d = tgt_pair;
    if (cls.bl_lo) target_d = tgt_lone;
    link_d = link_q;
    if (cls.bl_hi) link_d = cls.fused ? link_pair : link_hi;
    if (cls.bl_lo) link_d = link_lone;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect   <= 1'b0;
      new_pc     <= '0;
      link_q     <= '0;
      pair_fused <= 1'b0;
      swi_hit    <= 1'b0;
      undef_hit  <= 1'b0;
    end else begin
      redirect   <= issue & redirect_d;
      pair_fused <= issue & cls.fused;
      swi_hit    <= issue & cls.swi;
      undef_hit  <= issue & cls.undef;
      if (issue && redirect_d) new_pc <= target_d;
      if (issue && link_we)    link_q <= link_d;
    end
  end

  assign link = link_q;

  a_r10_pulse_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !redirect && !swi_hit && !undef_hit && !pair_fused);
  a_r10_link_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(link));
  a_r6_undef_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    undef_hit |-> !redirect);
  a_r2_swi_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    swi_hit |-> !redirect && !undef_hit);
  a_r8_fused_tags_link: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fused |-> redirect && link[0]);
  a_r4_untaken_keeps_link: assert property (@(posedge clk) disable iff (!rst_n)
    issue && cls.bcc && !cond_ok |=> !redirect && $stable(link));
endmodule

// File: tb/tb_cbl_unit.sv
module tb_cbl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] next_instr = '0;
  logic [31:0] pc = '0;
  logic        fn = 0, fz = 0, fc = 0, fv = 0;
  logic        redirect, pair_fused, swi_hit, undef_hit;
  logic [31:0] new_pc, link;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_link = '0;
  bit done = 0;

  always #10 clk = ~clk;

  cbl_unit dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .next_instr(next_instr), .pc(pc), .flag_n(fn), .flag_z(fz),
    .flag_c(fc), .flag_v(fv), .redirect(redirect), .new_pc(new_pc),
    .link(link), .pair_fused(pair_fused), .swi_hit(swi_hit),
    .undef_hit(undef_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cond_model(input int cc, input bit n, input bit z, input bit c, input bit v);
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return !(n ^ v);  11: return n ^ v;
      12: return !z && !(n ^ v);
      13: return z || (n ^ v);
      default: return 0;
    endcase
  endfunction

  // drive at negedge, sample 2 ns after the capturing posedge
  task automatic apply(input logic [15:0] i, input logic [15:0] nx, input logic [31:0] p, input logic [3:0] f);
    @(negedge clk);
    issue = 1; instr = i; next_instr = nx; pc = p;
    {fn, fz, fc, fv} = f;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string req, input bit rd, input logic [31:0] tgt,
                            input bit fu, input bit sw, input bit ud);
    chk(req, {31'b0, redirect}, {31'b0, rd});
    if (rd) chk(req, new_pc, tgt);
    chk(req, {31'b0, pair_fused}, {31'b0, fu});
    chk(req, {31'b0, swi_hit}, {31'b0, sw});
    chk(req, {31'b0, undef_hit}, {31'b0, ud});
    chk(req, link, exp_link);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    expect_out("R1", 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1;

    // R2 R3 R4: condition sweep over all codes and flag values
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0]  off  = 8'((cc * 16 + f) * 37);
        logic [31:0] p    = (f == 3) ? 32'hFFFF_FFF0 : 32'h0010_0000 + 32'(cc * 512 + f * 6);
        int          offv = $signed(off) * 2;
        logic [31:0] tgt  = p + 32'd4 + 32'(offv);
        bit          take;
        apply({4'b1101, 4'(cc), off}, 16'h0000, p, 4'(f));
        take = (cc < 14) && cond_model(cc, f[3], f[2], f[1], f[0]);
        if (cc >= 14) expect_out("R2", 0, 0, 0, cc == 15, cc == 14);
        else if (take) expect_out("R3_R4_taken", 1, tgt, 0, 0, 0);
        else expect_out("R4_untaken", 0, 0, 0, 0, 0);
      end
    end

    // R5 R11 unconditional branch
    for (int k = 0; k < 40; k++) begin
      logic [10:0] off  = (k == 0) ? 11'h3FF : (k == 1) ? 11'h400 : (k == 2) ? 11'h7FF : 11'(k * 97);
      logic [31:0] p    = (k == 0) ? 32'hFFFF_FFFE : 32'h2000_0000 + 32'(k * 2);
      int          offv = $signed(off) * 2;
      apply({5'd28, off}, 16'h0, p, 4'h0);
      expect_out("R5_R11", 1, p + 32'd4 + 32'(offv), 0, 0, 0);
    end

    // R6 opcode 29
    apply({5'd29, 11'h123}, 16'h0, 32'h100, 4'hF);
    expect_out("R6", 0, 0, 0, 0, 1);

    // R7 lone upper half, then R9 lone lower half using that link
    for (int k = 0; k < 8; k++) begin
      logic [10:0] hi = 11'(k * 263 + (k == 3 ? 11'h400 : 0));
      logic [10:0] lo = 11'(k * 151 + 5);
      logic [31:0] p  = 32'h0800_0000 + 32'(k * 4);
      int          hv = $signed(hi) * 4096;
      logic [31:0] old;
      apply({5'd30, hi}, {5'd28, 11'h0}, p, 4'h0);
      exp_link = p + 32'd4 + 32'(hv);
      expect_out("R7", 0, 0, 0, 0, 0);
      old = exp_link;
      apply({5'd31, lo}, 16'h0, p + 32'd2, 4'h0);
      exp_link = (p + 32'd4) | 32'd1;
      expect_out("R9", 1, old + {20'b0, lo, 1'b0}, 0, 0, 0);
    end

    // R8 fused pair, then R9 lone half chained on the tagged link
    for (int k = 0; k < 8; k++) begin
      logic [10:0] hi = (k == 0) ? 11'h7FF : 11'(k * 331);
      logic [10:0] lo = 11'(k * 77 + 1);
      logic [31:0] p  = (k == 1) ? 32'hFFFF_FFFC : 32'h4000_0000 + 32'(k * 10);
      int          hv = $signed(hi) * 4096;
      logic [31:0] mid = p + 32'd4 + 32'(hv);
      logic [31:0] old;
      apply({5'd30, hi}, {5'd31, lo}, p, 4'h5);
      exp_link = (p + 32'd4) | 32'd1;
      expect_out("R8", 1, mid + {20'b0, lo, 1'b0}, 1, 0, 0);
      old = exp_link;
      apply({5'd31, 11'h10}, 16'h0, 32'h0000_2000, 4'h0);
      exp_link = 32'h0000_2003;
      expect_out("R9_chain", 1, old + 32'h20, 0, 0, 0);
    end

    // R10 non-branch opcodes have no effect
    for (int op = 0; op < 26; op++) begin
      apply({5'(op), 11'h5A5}, {5'd31, 11'h1}, 32'h300, 4'hF);
      expect_out("R10_nonbranch", 0, 0, 0, 0, 0);
    end

    // R10 no issue: a branch held on the inputs does nothing
    @(negedge clk);
    issue = 0; instr = {5'd31, 11'h7}; pc = 32'h500;
    @(posedge clk); #2;
    expect_out("R10_idle", 0, 0, 0, 0, 0);
    @(posedge clk); #2;
    expect_out("R10_idle2", 0, 0, 0, 0, 0);

    // R10 pulse lasts one cycle after an issued branch
    apply({5'd28, 11'h2}, 16'h0, 32'h600, 4'h0);
    expect_out("R5", 1, 32'h608, 0, 0, 0);
    @(negedge clk); issue = 0;
    @(posedge clk); #2;
    expect_out("R10_pulse", 0, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule